// File: doc/BRIEF.md
# SDIO Function Mailbox Register Window

This block is the byte-wide register file that an SDIO function-1 data path reaches. It decodes a 14-bit byte address space. The space holds four target status bytes and four interrupt enable bytes. It also holds a frame byte, a lookahead-valid byte, four lookahead bytes, eight scratch bytes, and eight credit counters, each with a second decrement view. A read-only card information window and four 2 KB mailbox windows complete the map. Every byte written into a mailbox is stored and counted against that mailbox. The counts leave the block on a dedicated output.

Bytes arrive in one of two ways. The first is a single-cycle byte access with an explicit address. The second is a burst: a block-transfer argument is loaded first, then one byte moves per beat. Each beat either advances the address or holds it, as the argument selects. Read data comes back one cycle after the access.

While the target is still in boot mode, the block watches mailbox 0. A write to its final byte raises a one-cycle command strobe that carries the mailbox 0 byte count. A boot-command handler outside the block then answers by loading credit counter 4 with its response length.

Top module: `sdio_mbox_regwin`

## Requirements
- R1: After reset, all eight credit counters read 0x00, all eight decrement views read 0xFF, every mailbox count in `mbox_fill` is 0, and `cmd_strobe` is low.
- R2: The frame byte (0x404), lookahead-valid byte (0x405), lookahead bytes (0x408, 0x40C, 0x410, 0x414), enable bytes (0x418–0x41B) and scratch bytes (0x460–0x467) store host writes. A read returns the stored value on `rsp_rdata`, with `rsp_valid` high, in the cycle after the access.
- R3: A read of status byte 0x400+i returns `tgt_status[8i+7:8i]`, and host writes to 0x400–0x403 have no effect.
- R4: Counter n reads at 0x420+n and its decrement view at 0x440+4n. Other offsets in 0x440–0x45F read 0, and host writes to the counter areas are ignored.
- R5: A read at 0x600+k returns (CIS_SEED + 3k) mod 256 for k < CIS_LEN, and 0 at or beyond CIS_LEN.
- R6: Unmapped addresses read 0. This covers 0x468–0x4FF, 0x406 and addresses from 0x2800 upward. Writes to them change nothing readable.
- R7: A write at 0x800–0x27FF stores the byte in mailbox m = (addr−0x800)>>11. The offset within the window is taken modulo 2^MB_STORE_LOG2, so with the default of 9 the offsets 0x010 and 0x210 alias. A read returns the stored byte.
- R8: Each mailbox write adds one to that mailbox's count, which is `mbox_fill[12m+11:12m]`. The only exception is the command-firing write in R10.
- R9: While `boot_done` is low, any mailbox 0 write clears counter 4 and its decrement view to 0x00. While `boot_done` is high, it leaves them unchanged.
- R10: While `boot_done` is low, a mailbox 0 write whose low 11 address bits are all ones pulses `cmd_strobe` for one cycle after the write. `cmd_len` then equals the mailbox 0 count including that byte, and the count reads 0. This does not happen in other mailboxes, or while `boot_done` is high.
- R11: `cmd_resp_valid` loads counter 4 with `cmd_resp_len` and sets its decrement view to 0xFF. It has priority over the clearing in R9.
- R12: `xfer_load` captures the argument fields: bit 31 selects write (1) or read (0), bit 26 selects incrementing addresses (1) or a fixed address (0), and bits 22:9 give the start address. Each `beat_valid` performs one byte access at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Single byte access request |
| acc_write | input | 1 | 1 = write, 0 = read for the single access |
| acc_addr | input | 14 | Byte address of the single access |
| acc_wdata | input | 8 | Write byte of the single access |
| xfer_load | input | 1 | Load a block-transfer argument |
| xfer_arg | input | 32 | Block-transfer argument |
| beat_valid | input | 1 | One burst byte at the current burst address |
| beat_wdata | input | 8 | Write byte of a burst beat |
| boot_done | input | 1 | High once boot mode has finished |
| cmd_resp_valid | input | 1 | Boot handler posts a response length |
| cmd_resp_len | input | 8 | Response length written into counter 4 |
| tgt_status | input | 32 | Four target status bytes, byte i at 0x400+i |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 8 | Read data |
| cmd_strobe | output | 1 | Boot command ready in mailbox 0 |
| cmd_len | output | 12 | Mailbox 0 byte count carried by the strobe |
| mbox_fill | output | 48 | Four 12-bit mailbox byte counts, mailbox m at bits 12m+11:12m |

## Verification
The assertions assume three things about the inputs. A single access and a burst beat never arrive in the same cycle. All request inputs stay low while reset is held, so the one-cycle read response and the counter checks start from a quiet state. The counter-4 clearing check also assumes that no response length is posted in the same cycle as a mailbox 0 write. The bench keeps within these assumptions because every stimulus task drives exactly one request for one cycle and then returns it to idle. Expected values come from a small model kept in the bench: mailbox counts, the card information arithmetic and the decode table.

// File: rtl/sdio_mbox_regwin.sv
module sdio_mbox_regwin #(
  parameter int CIS_LEN       = 32,
  parameter int CIS_SEED      = 8'h5A,
  parameter int MB_STORE_LOG2 = 9,
  parameter int CNT_W         = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [13:0]        acc_addr,
  input  logic [7:0]         acc_wdata,
  input  logic               xfer_load,
  input  logic [31:0]        xfer_arg,
  input  logic               beat_valid,
  input  logic [7:0]         beat_wdata,
  input  logic               boot_done,
  input  logic               cmd_resp_valid,
  input  logic [7:0]         cmd_resp_len,
  input  logic [31:0]        tgt_status,
  output logic               rsp_valid,
  output logic [7:0]         rsp_rdata,
  output logic               cmd_strobe,
  output logic [CNT_W-1:0]   cmd_len,
  output logic [4*CNT_W-1:0] mbox_fill
);
  localparam int RAM_AW    = MB_STORE_LOG2 + 2;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic        x_dir, x_inc;
  logic [13:0] x_ptr;

  wire        go = acc_valid | beat_valid;
  wire        wr = beat_valid ? x_dir : acc_write;
  wire [13:0] a  = beat_valid ? x_ptr : acc_addr;
  wire [7:0]  wd = beat_valid ? beat_wdata : acc_wdata;
  wire do_wr = go & wr;
  wire do_rd = go & ~wr;

  wire       in_mb   = (a >= 14'h0800) && (a <= 14'h27FF);
  wire [1:0] mb      = 2'(a[13:11] - 3'd1);
  wire       mb_last = &a[10:0];
  wire       mb0_wr  = do_wr && in_mb && (mb == 2'd0) && !boot_done;
  wire [RAM_AW-1:0] ridx = {mb, a[MB_STORE_LOG2-1:0]};
  wire unused_arg = ^{xfer_arg[30:27], xfer_arg[25:23], xfer_arg[8:0]};

  logic [7:0] frame, la_vld;
  logic [7:0] la [4];
  logic [7:0] ena [4];
  logic [7:0] scr [8];
  logic [7:0] cnt [8];
  logic [7:0] dec [8];
  logic [CNT_W-1:0] fill [4];
  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] ram_q, reg_q, reg_d;
  logic       sel_ram;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_dir <= 1'b0; x_inc <= 1'b0; x_ptr <= '0;
    end else if (xfer_load) begin
      x_dir <= xfer_arg[31];
      x_inc <= xfer_arg[26];
      x_ptr <= xfer_arg[22:9];
    end else if (beat_valid && x_inc) begin
      x_ptr <= x_ptr + 14'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '0; la_vld <= '0;
      for (int i = 0; i < 4; i++) begin la[i] <= '0; ena[i] <= '0; end
      for (int i = 0; i < 8; i++) scr[i] <= '0;
    end else if (do_wr) begin
      if (a == 14'h404) frame <= wd;
      else if (a == 14'h405) la_vld <= wd;
      else if (a >= 14'h408 && a <= 14'h417 && a[1:0] == 2'b00) la[2'(a[4:2] - 3'd2)] <= wd;
      else if (a[13:2] == 12'h106) ena[a[1:0]] <= wd;
      else if (a[13:3] == 11'h08C) scr[a[2:0]] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_strobe <= 1'b0;
      cmd_len    <= '0;
      for (int i = 0; i < 4; i++) fill[i] <= '0;
      for (int i = 0; i < 8; i++) begin cnt[i] <= 8'h00; dec[i] <= 8'hFF; end
    end else begin
      cmd_strobe <= 1'b0;
      if (do_wr && in_mb) begin
        if (mb0_wr && mb_last) begin
          cmd_strobe <= 1'b1;
          cmd_len    <= fill[0] + 1'b1;
          fill[0]    <= '0;
        end else begin
          fill[mb] <= fill[mb] + 1'b1;
        end
      end
      if (cmd_resp_valid) begin
        cnt[4] <= cmd_resp_len;
        dec[4] <= 8'hFF;
      end else if (mb0_wr) begin
        cnt[4] <= 8'h00;
        dec[4] <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && in_mb) ram[ridx] <= wd;
    if (do_rd) ram_q <= ram[ridx];
  end

  always_comb begin
    reg_d = 8'h00;
    if (a[13:2] == 12'h100) reg_d = tgt_status[8*a[1:0] +: 8];
    else if (a == 14'h404) reg_d = frame;
    else if (a == 14'h405) reg_d = la_vld;
    else if (a >= 14'h408 && a <= 14'h417 && a[1:0] == 2'b00) reg_d = la[2'(a[4:2] - 3'd2)];
    else if (a[13:2] == 12'h106) reg_d = ena[a[1:0]];
    else if (a[13:3] == 11'h084) reg_d = cnt[a[2:0]];
    else if (a[13:5] == 9'h022 && a[1:0] == 2'b00) reg_d = dec[a[4:2]];
    else if (a[13:3] == 11'h08C) reg_d = scr[a[2:0]];
    else if (a[13:9] == 5'h03 && 32'(a[8:0]) < CIS_LEN) reg_d = 8'(CIS_SEED + 3 * a[8:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; sel_ram <= 1'b0; reg_q <= '0;
    end else begin
      rsp_valid <= do_rd;
      sel_ram   <= in_mb;
      reg_q     <= reg_d;
    end
  end

  assign rsp_rdata = sel_ram ? ram_q : reg_q;

  for (genvar m = 0; m < 4; m++) begin : g_fill
    assign mbox_fill[m*CNT_W +: CNT_W] = fill[m];
  end

  assert_one_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && beat_valid));
  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(do_rd));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && in_mb && mb == 2'd1) |=> fill[1] == $past(fill[1]) + 1'b1);
  assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(go && wr && a[13:11] == 3'd1 && mb_last && !boot_done));
  assert_fill_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> fill[0] == '0);
  assert_boot_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mb0_wr && !cmd_resp_valid) |=> (cnt[4] == 8'h00 && dec[4] == 8'h00));
  assert_resp_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_resp_valid |=> (cnt[4] == $past(cmd_resp_len) && dec[4] == 8'hFF));
endmodule

// File: tb/sdio_mbox_regwin_tb.sv
`timescale 1ns/1ps
module sdio_mbox_regwin_tb_top;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, xfer_load = 0, beat_valid = 0;
  logic boot_done = 0, cmd_resp_valid = 0;
  logic [13:0] acc_addr = 0;
  logic [7:0]  acc_wdata = 0, beat_wdata = 0, cmd_resp_len = 0;
  logic [31:0] xfer_arg = 0, tgt_status = 32'hA1B2C3D4;
  logic rsp_valid, cmd_strobe;
  logic [7:0] rsp_rdata;
  logic [11:0] cmd_len;
  logic [47:0] mbox_fill;
  int tests = 0, fails = 0;
  int efill [4];

  always #2 clk = ~clk;

  sdio_mbox_regwin dut_i (.clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata,
    .xfer_load, .xfer_arg, .beat_valid, .beat_wdata, .boot_done, .cmd_resp_valid,
    .cmd_resp_len, .tgt_status, .rsp_valid, .rsp_rdata, .cmd_strobe, .cmd_len, .mbox_fill);

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [7:0] d);
    @(negedge clk); acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk); acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(logic [13:0] a, output logic [7:0] q);
    @(negedge clk); acc_valid = 1; acc_write = 0; acc_addr = a;
    @(negedge clk); acc_valid = 0;
    chk("R2 rsp_valid", int'(rsp_valid), 1);
    q = rsp_rdata;
  endtask

  task automatic load(bit w, bit inc, logic [13:0] a);
    @(negedge clk); xfer_load = 1; xfer_arg = {w, 4'b0, inc, 3'b0, a, 9'b0};
    @(negedge clk); xfer_load = 0;
  endtask

  task automatic beat(logic [7:0] d, output logic [7:0] q);
    @(negedge clk); beat_valid = 1; beat_wdata = d;
    @(negedge clk); beat_valid = 0;
    q = rsp_rdata;
  endtask

  task automatic resp(logic [7:0] n);
    @(negedge clk); cmd_resp_valid = 1; cmd_resp_len = n;
    @(negedge clk); cmd_resp_valid = 0;
  endtask

  task automatic chk_fill(string tag);
    for (int m = 0; m < 4; m++) chk(tag, int'(mbox_fill[12*m +: 12]), efill[m]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    for (int m = 0; m < 4; m++) efill[m] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 strobe", int'(cmd_strobe), 0);
    chk_fill("R1 fill");
    for (int n = 0; n < 8; n++) begin
      rd(14'h420 + 14'(n), q); chk("R1 counter", q, 0);
      rd(14'h440 + 14'(4*n), q); chk("R1 dec view", q, 8'hFF);
    end

    // R2 writable bytes
    wr(14'h404, 8'h3C); wr(14'h405, 8'h0F);
    for (int i = 0; i < 4; i++) begin
      wr(14'h408 + 14'(4*i), 8'(8'h70 + i));
      wr(14'h418 + 14'(i), 8'(8'h90 + 5*i));
    end
    for (int i = 0; i < 8; i++) wr(14'h460 + 14'(i), 8'(37*i + 1));
    rd(14'h404, q); chk("R2 frame", q, 8'h3C);
    rd(14'h405, q); chk("R2 la valid", q, 8'h0F);
    for (int i = 0; i < 4; i++) begin
      rd(14'h408 + 14'(4*i), q); chk("R2 lookahead", q, 8'h70 + i);
      rd(14'h418 + 14'(i), q); chk("R2 enable", q, (8'h90 + 5*i) & 8'hFF);
    end
    for (int i = 0; i < 8; i++) begin
      rd(14'h460 + 14'(i), q); chk("R2 scratch", q, (37*i + 1) & 8'hFF);
    end

    // R3 status
    for (int i = 0; i < 4; i++) begin
      rd(14'h400 + 14'(i), q); chk("R3 status", q, (tgt_status >> (8*i)) & 8'hFF);
    end
    wr(14'h400, 8'h00);
    rd(14'h400, q); chk("R3 status write ignored", q, 8'hD4);

    // R4 counter area decode and write ignore
    wr(14'h421, 8'h55); wr(14'h444, 8'h12);
    rd(14'h421, q); chk("R4 counter write ignored", q, 0);
    rd(14'h444, q); chk("R4 dec write ignored", q, 8'hFF);
    for (int o = 0; o < 32; o++) begin
      rd(14'h440 + 14'(o), q); chk("R4 dec region", q, (o % 4 == 0) ? 8'hFF : 0);
    end

    // R5 card information window
    for (int k = 0; k < 36; k++) begin
      rd(14'h600 + 14'(k), q); chk("R5 cis", q, (k < 32) ? ((8'h5A + 3*k) & 8'hFF) : 0);
    end

    // R6 unmapped
    wr(14'h468, 8'hEE); rd(14'h468, q); chk("R6 timeout addr", q, 0);
    wr(14'h406, 8'hEE); rd(14'h406, q); chk("R6 gap addr", q, 0);
    wr(14'h2800, 8'hEE); rd(14'h2800, q); chk("R6 above mailboxes", q, 0);
    chk_fill("R6 fill unchanged");

    // R7/R8 mailbox store and count
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++) begin
        wr(14'h800 + 14'(m*2048 + k), 8'(m*16 + k));
        efill[m]++;
        chk_fill("R8 count");
      end
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++) begin
        rd(14'h800 + 14'(m*2048 + k), q); chk("R7 mailbox data", q, m*16 + k);
      end
    wr(14'h1810, 8'hA5); efill[2]++;
    wr(14'h1A10, 8'h5A); efill[2]++;
    rd(14'h1810, q); chk("R7 alias", q, 8'h5A);
    chk_fill("R8 count alias");

    // R11, R9, R10 boot path
    resp(8'h07);
    rd(14'h424, q); chk("R11 counter 4", q, 7);
    rd(14'h450, q); chk("R11 dec 4", q, 8'hFF);
    wr(14'h805, 8'h11); efill[0]++;
    rd(14'h424, q); chk("R9 counter 4 cleared", q, 0);
    rd(14'h450, q); chk("R9 dec 4 cleared", q, 0);
    wr(14'h0FFF, 8'h22);
    chk("R10 strobe", int'(cmd_strobe), 1);
    chk("R10 cmd_len", int'(cmd_len), efill[0] + 1);
    efill[0] = 0;
    chk_fill("R10 count cleared");
    wr(14'h17FF, 8'h33); efill[1]++;
    chk("R10 no strobe mailbox 1", int'(cmd_strobe), 0);
    chk_fill("R8 count mailbox 1 last");
    boot_done = 1;
    resp(8'h09);
    wr(14'h0FFF, 8'h44); efill[0]++;
    chk("R10 no strobe after boot", int'(cmd_strobe), 0);
    chk_fill("R8 count after boot");
    rd(14'h424, q); chk("R9 counter 4 kept", q, 9);
    rd(14'h450, q); chk("R9 dec 4 kept", q, 8'hFF);

    // R12 bursts
    load(1'b1, 1'b1, 14'h460);
    for (int i = 0; i < 4; i++) beat(8'(8'hC0 + i), q);
    for (int i = 0; i < 4; i++) begin
      rd(14'h460 + 14'(i), q); chk("R12 incr write", q, 8'hC0 + i);
    end
    rd(14'h464, q); chk("R12 incr stop", q, (37*4 + 1) & 8'hFF);
    load(1'b0, 1'b1, 14'h461);
    for (int i = 0; i < 3; i++) begin
      beat(8'h00, q); chk("R12 incr read", q, 8'hC1 + i);
    end
    load(1'b1, 1'b0, 14'h2000);
    for (int i = 0; i < 3; i++) begin beat(8'(8'hE0 + i), q); efill[3]++; end
    chk_fill("R12 fixed count");
    load(1'b0, 1'b0, 14'h2000);
    for (int i = 0; i < 2; i++) begin
      beat(8'h00, q); chk("R12 fixed read", q, 8'hE2);
    end
    rd(14'h2001, q); chk("R12 fixed untouched", q, 8'h31);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule